// File: doc/BRIEF.md
# Planar Video Memory Write Datapath

This block turns one CPU byte store into a video memory write. The memory is organised as 32-bit words, each holding one byte for each of four planes. The block decodes the store address against the active host window, then picks one of three write paths:

- **Packed-chain**: each byte goes to one plane picked by the low address bits.
- **Paired-plane (odd/even)**: the plane is picked from the odd/even address bit and one configuration bit.
- **Planar raster-op**: builds a full 32-bit word from the store data, the set/reset values and the latch word returned by the read path.

The result is registered and presented one cycle later as:

- a word address,
- a 4-bit plane byte-enable,
- 32 bits of write data.

A sticky four-bit flag records every plane that a store has enabled. Software-visible configuration arrives on plain input pins held by the surrounding register file. The block records each accepted store in a small state machine. The state says which path produced the store now on the memory port.

The states are:

- `ST_IDLE`: no store on the last cycle.
- `ST_DROP`: a store that missed the window or had no plane enabled.
- `ST_CHAIN4`
- `ST_ODDEVEN`
- `ST_PLANAR`

Every state can move to every state on the next clock. The move depends only on the store offered in that cycle:

- no `wr_valid` → `ST_IDLE`
- a window miss or all byte-enables zero → `ST_DROP`
- otherwise, the path chosen by the priority packed-chain, then paired-plane, then planar.

Top module: `planar_wr_path`

## Requirements
- R1: After reset, `mem_we` is 0 and `plane_updated` is 0.
- R2: The window is decoded from `map_sel`:
  - 0 accepts any 17-bit offset as is.
  - 1 accepts offsets below 0x10000 and adds `bank_off`, modulo 2^19.
  - 2 accepts 0x10000..0x17FFF and subtracts 0x10000.
  - 3 accepts 0x18000..0x1FFFF and subtracts 0x18000.

  A store outside the window gives no write and leaves `plane_updated` unchanged.
- R3: With `chain4_en`=1, the plane is offset bits [1:0], the word address is offset/4, all four lanes carry the store byte, and the byte-enable is one-hot on that plane. If that plane's `map_mask` bit is 0, no write occurs.
- R4: With `oddeven_en`=1 and `chain4_en`=0, the plane is {`plane_sel`[1], offset[0]} and the word address is offset/2. All lanes carry the byte, and the write is gated by that plane's `map_mask` bit.
- R5: Planar `write_mode`=0 rotates the byte right by `rot_cnt` and copies it to every plane. Planes whose `sr_enable` bit is 1 take 0xFF or 0x00 from their `sr_value` bit instead.
- R6: Planar `write_mode`=1 writes the latch word unchanged, whatever `logic_fn` and `bit_mask` are.
- R7: Planar `write_mode`=2 fills plane p with 0xFF if store bit p is 1, else 0x00.
- R8: Planar `write_mode`=3 fills plane p from `sr_value` bit p, using (`bit_mask` AND rotated byte) as the bit mask.
- R9: `logic_fn` combines the mode 0/2/3 value with the latch before masking: 0 pass, 1 AND, 2 OR, 3 XOR.
- R10: Bits with a 1 in the effective bit mask come from the new value and the others from the latch, in every plane.
- R11: A planar store uses `map_mask` as the byte-enable and the offset as the word address. A zero `map_mask` gives no write.
- R12: `plane_updated` ORs in the byte-enable of each write and holds otherwise. `upd_clr` zeroes it on the next edge. When a clear and a write meet, only the write's planes remain set.
- R13: A store sampled at clock edge k appears on the memory port after edge k. With no `wr_valid`, `mem_we` is 0.
- R14: `chain4_en` takes priority over `oddeven_en`, and both take priority over the planar path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_valid | input | 1 | a store is offered this cycle |
| wr_addr | input | 17 | store offset inside the host aperture |
| wr_data | input | 8 | store byte |
| map_sel | input | 2 | window selection |
| bank_off | input | 19 | bank base added in window 1 |
| chain4_en | input | 1 | packed-chain path |
| oddeven_en | input | 1 | paired-plane path |
| plane_sel | input | 2 | plane select (bit 1 used by paired-plane path) |
| write_mode | input | 2 | planar write mode 0..3 |
| rot_cnt | input | 3 | right-rotate count |
| logic_fn | input | 2 | latch combine function |
| sr_value | input | 4 | set/reset value, one bit per plane |
| sr_enable | input | 4 | set/reset enable, one bit per plane |
| bit_mask | input | 8 | bit mask |
| map_mask | input | 4 | plane write enable |
| latch | input | 32 | latch word from the read path |
| upd_clr | input | 1 | clear plane-updated flags |
| mem_we | output | 1 | memory write strobe |
| mem_addr | output | 19 | memory word address |
| mem_be | output | 4 | plane byte-enables |
| mem_wdata | output | 32 | write word, plane p in bits 8p+7..8p |
| plane_updated | output | 4 | sticky per-plane written flags |

## Verification
Directed stores try each window selection with offsets just inside and just outside its bounds. This tells a correct range test from an off-by-one and separates bank addition from a plain pass-through. The packed-chain and paired-plane paths are driven at all four plane positions with selected planes masked off. This separates address scaling and one-hot lane choice from the map-mask gate. Each planar write mode is then run with latch and store patterns whose bits differ between planes, under each combine function and partial bit masks. A swapped mode, function or mask source thus changes the word. A long stretch of pseudo-random stores covering every configuration follows.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DROP    = 3'd1,
        ST_CHAIN4  = 3'd2,
        ST_ODDEVEN = 3'd3,
        ST_PLANAR  = 3'd4
    } wr_state_t;

    typedef enum logic [1:0] {
        WM_ROTATE = 2'd0,
        WM_LATCH  = 2'd1,
        WM_NIBBLE = 2'd2,
        WM_MASKED = 2'd3
    } wmode_t;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } logic_fn_t;

endpackage

// File: rtl/pwp_window.sv
module pwp_window #(
    parameter int WIN_AW = 17,
    parameter int OFF_W  = 19
) (
    input  logic [WIN_AW-1:0] addr,
    input  logic [1:0]        map_sel,
    input  logic [OFF_W-1:0]  bank_off,
    output logic              hit,
    output logic [OFF_W-1:0]  off
);
    localparam int HALF_AW    = WIN_AW - 1;
    localparam int QUARTER_AW = WIN_AW - 2;

    logic [1:0] top_bits;
    assign top_bits = addr[WIN_AW-1 -: 2];

    always_comb begin
        hit = 1'b0;
        off = '0;
        unique case (map_sel)
            2'd0: begin
                hit = 1'b1;
                off = OFF_W'(addr);
            end
            2'd1: begin
                hit = ~addr[WIN_AW-1];
                off = OFF_W'(addr[HALF_AW-1:0]) + bank_off;
            end
            2'd2: begin
                hit = (top_bits == 2'b10);
                off = OFF_W'(addr[QUARTER_AW-1:0]);
            end
            2'd3: begin
                hit = (top_bits == 2'b11);
                off = OFF_W'(addr[QUARTER_AW-1:0]);
            end
        endcase
    end
endmodule

// File: rtl/pwp_rop.sv
module pwp_rop
    import pwp_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int NPLANE = 4,
    localparam int RC_W  = $clog2(LANE_W),
    localparam int WORD_W = LANE_W * NPLANE
) (
    input  logic [LANE_W-1:0] data,
    input  logic [WORD_W-1:0] latch,
    input  wmode_t            mode,
    input  logic [RC_W-1:0]   rot,
    input  logic_fn_t         fn,
    input  logic [NPLANE-1:0] sr_val,
    input  logic [NPLANE-1:0] sr_en,
    input  logic [LANE_W-1:0] bit_mask,
    output logic [WORD_W-1:0] result
);
    logic [2*LANE_W-1:0] dbl;
    logic [LANE_W-1:0]   rotd;

    assign dbl  = {data, data} >> rot;
    assign rotd = dbl[LANE_W-1:0];

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [LANE_W-1:0] old_b;
        logic [LANE_W-1:0] src_b;
        logic [LANE_W-1:0] msk_b;
        logic [LANE_W-1:0] opd_b;

        assign old_b = latch[p*LANE_W +: LANE_W];

        always_comb begin
            src_b = rotd;
            msk_b = bit_mask;
            unique case (mode)
                WM_ROTATE: begin
                    src_b = sr_en[p] ? {LANE_W{sr_val[p]}} : rotd;
                    msk_b = bit_mask;
                end
                WM_LATCH: begin
                    src_b = old_b;
                    msk_b = '1;
                end
                WM_NIBBLE: begin
                    src_b = {LANE_W{data[p]}};
                    msk_b = bit_mask;
                end
                WM_MASKED: begin
                    src_b = {LANE_W{sr_val[p]}};
                    msk_b = bit_mask & rotd;
                end
            endcase
        end

        always_comb begin
            opd_b = src_b;
            if (mode != WM_LATCH) begin
                unique case (fn)
                    FN_PASS: opd_b = src_b;
                    FN_AND:  opd_b = src_b & old_b;
                    FN_OR:   opd_b = src_b | old_b;
                    FN_XOR:  opd_b = src_b ^ old_b;
                endcase
            end
        end

        assign result[p*LANE_W +: LANE_W] = (opd_b & msk_b) | (old_b & ~msk_b);
    end
endmodule

// File: rtl/pwp_route.sv
module pwp_route
    import pwp_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int NPLANE = 4,
    parameter int OFF_W  = 19,
    localparam int PL_W  = $clog2(NPLANE),
    localparam int WORD_W = LANE_W * NPLANE
) (
    input  logic              valid,
    input  logic              hit,
    input  logic [OFF_W-1:0]  off,
    input  logic              chain4,
    input  logic              oddeven,
    input  logic [PL_W-1:0]   plane_sel,
    input  logic [NPLANE-1:0] map_mask,
    input  logic [LANE_W-1:0] data,
    input  logic [WORD_W-1:0] rop_word,
    output wr_state_t         kind,
    output logic [OFF_W-1:0]  addr,
    output logic [NPLANE-1:0] be,
    output logic [WORD_W-1:0] wdata
);
    logic [PL_W-1:0]   pl;
    logic [NPLANE-1:0] onehot;
    wr_state_t         path;

    always_comb begin
        pl     = '0;
        path   = ST_PLANAR;
        addr   = off;
        wdata  = rop_word;
        if (chain4) begin
            path  = ST_CHAIN4;
            pl    = off[PL_W-1:0];
            addr  = off >> PL_W;
            wdata = {NPLANE{data}};
        end else if (oddeven) begin
            path  = ST_ODDEVEN;
            pl    = {plane_sel[PL_W-1:1], off[0]};
            addr  = off >> 1;
            wdata = {NPLANE{data}};
        end
        onehot = NPLANE'(1) << pl;
    end

    always_comb begin
        be   = '0;
        kind = ST_IDLE;
        if (valid) begin
            if (!hit) begin
                kind = ST_DROP;
            end else begin
                be   = (path == ST_PLANAR) ? map_mask : (map_mask & onehot);
                kind = (be != '0) ? path : ST_DROP;
            end
        end
    end
endmodule

// File: rtl/planar_wr_path.sv
module planar_wr_path
    import pwp_pkg::*;
#(
    parameter int WIN_AW = 17,
    parameter int OFF_W  = 19,
    parameter int LANE_W = 8,
    parameter int NPLANE = 4,
    localparam int PL_W   = $clog2(NPLANE),
    localparam int RC_W   = $clog2(LANE_W),
    localparam int WORD_W = LANE_W * NPLANE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WIN_AW-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [1:0]        map_sel,
    input  logic [OFF_W-1:0]  bank_off,
    input  logic              chain4_en,
    input  logic              oddeven_en,
    input  logic [PL_W-1:0]   plane_sel,
    input  logic [1:0]        write_mode,
    input  logic [RC_W-1:0]   rot_cnt,
    input  logic [1:0]        logic_fn,
    input  logic [NPLANE-1:0] sr_value,
    input  logic [NPLANE-1:0] sr_enable,
    input  logic [LANE_W-1:0] bit_mask,
    input  logic [NPLANE-1:0] map_mask,
    input  logic [WORD_W-1:0] latch,
    input  logic              upd_clr,
    output logic              mem_we,
    output logic [OFF_W-1:0]  mem_addr,
    output logic [NPLANE-1:0] mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [NPLANE-1:0] plane_updated
);
    logic              win_hit;
    logic [OFF_W-1:0]  win_off;
    logic [WORD_W-1:0] rop_word;
    wr_state_t         nxt_state;
    wr_state_t         state_q;
    logic [OFF_W-1:0]  rt_addr;
    logic [NPLANE-1:0] rt_be;
    logic [WORD_W-1:0] rt_wdata;
    logic [OFF_W-1:0]  addr_q;
    logic [NPLANE-1:0] be_q;
    logic [WORD_W-1:0] wdata_q;
    logic [NPLANE-1:0] upd_q;

    pwp_window #(.WIN_AW(WIN_AW), .OFF_W(OFF_W)) u_window (
        .addr     (wr_addr),
        .map_sel  (map_sel),
        .bank_off (bank_off),
        .hit      (win_hit),
        .off      (win_off)
    );

    pwp_rop #(.LANE_W(LANE_W), .NPLANE(NPLANE)) u_rop (
        .data     (wr_data),
        .latch    (latch),
        .mode     (wmode_t'(write_mode)),
        .rot      (rot_cnt),
        .fn       (logic_fn_t'(logic_fn)),
        .sr_val   (sr_value),
        .sr_en    (sr_enable),
        .bit_mask (bit_mask),
        .result   (rop_word)
    );

    pwp_route #(.LANE_W(LANE_W), .NPLANE(NPLANE), .OFF_W(OFF_W)) u_route (
        .valid     (wr_valid),
        .hit       (win_hit),
        .off       (win_off),
        .chain4    (chain4_en),
        .oddeven   (oddeven_en),
        .plane_sel (plane_sel),
        .map_mask  (map_mask),
        .data      (wr_data),
        .rop_word  (rop_word),
        .kind      (nxt_state),
        .addr      (rt_addr),
        .be        (rt_be),
        .wdata     (rt_wdata)
    );

    // state register: records which path produced the store now on the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= nxt_state;
        end
    end

    // operand stage and sticky plane flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            upd_q   <= '0;
        end else begin
            addr_q  <= rt_addr;
            be_q    <= rt_be;
            wdata_q <= rt_wdata;
            upd_q   <= (upd_clr ? '0 : upd_q) | rt_be;
        end
    end

    // output decode from the state
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE, ST_DROP: begin
                mem_we = 1'b0;
            end
            ST_CHAIN4, ST_ODDEVEN, ST_PLANAR: begin
                mem_we    = 1'b1;
                mem_addr  = addr_q;
                mem_be    = be_q;
                mem_wdata = wdata_q;
            end
            default: begin
                mem_we = 1'b0;
            end
        endcase
    end

    assign plane_updated = upd_q;
endmodule

// File: rtl/pwp_checker.sv
module pwp_checker #(
    parameter int WIN_AW = 17,
    parameter int OFF_W  = 19,
    parameter int NPLANE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [WIN_AW-1:0] wr_addr,
    input logic [1:0]        map_sel,
    input logic              chain4_en,
    input logic              oddeven_en,
    input logic              upd_clr,
    input logic              mem_we,
    input logic [NPLANE-1:0] mem_be,
    input logic [NPLANE-1:0] plane_updated
);
    assert_idle_no_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !mem_we);

    assert_window_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && map_sel == 2'd2 && wr_addr[WIN_AW-1 -: 2] != 2'b10) |=> !mem_we);

    assert_chain_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && chain4_en) |=> $onehot0(mem_be));

    assert_oddeven_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && oddeven_en) |=> ($countones(mem_be) <= 1));

    assert_write_has_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != '0));

    assert_flags_cover_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((plane_updated & mem_be) == mem_be));

    assert_flags_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_clr |=> ((plane_updated & $past(plane_updated)) == $past(plane_updated)));

    assert_flags_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_clr && !wr_valid) |=> (plane_updated == '0));
endmodule

bind planar_wr_path pwp_checker #(
    .WIN_AW (WIN_AW),
    .OFF_W  (OFF_W),
    .NPLANE (NPLANE)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .map_sel       (map_sel),
    .chain4_en     (chain4_en),
    .oddeven_en    (oddeven_en),
    .upd_clr       (upd_clr),
    .mem_we        (mem_we),
    .mem_be        (mem_be),
    .plane_updated (plane_updated)
);

// File: tb/planar_wr_path_tb_top.sv
`timescale 1ns/1ps
module planar_wr_path_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  map_sel = '0;
    logic [18:0] bank_off = '0;
    logic        chain4_en = 1'b0;
    logic        oddeven_en = 1'b0;
    logic [1:0]  plane_sel = '0;
    logic [1:0]  write_mode = '0;
    logic [2:0]  rot_cnt = '0;
    logic [1:0]  logic_fn = '0;
    logic [3:0]  sr_value = '0;
    logic [3:0]  sr_enable = '0;
    logic [7:0]  bit_mask = 8'hFF;
    logic [3:0]  map_mask = 4'hF;
    logic [31:0] latch = '0;
    logic        upd_clr = 1'b0;
    logic        mem_we;
    logic [18:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [3:0]  plane_updated;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        e_we;
    logic [18:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_data;
    logic [3:0]  e_upd = '0;

    always #2 clk = ~clk;

    planar_wr_path dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .map_sel(map_sel), .bank_off(bank_off),
        .chain4_en(chain4_en), .oddeven_en(oddeven_en), .plane_sel(plane_sel),
        .write_mode(write_mode), .rot_cnt(rot_cnt), .logic_fn(logic_fn),
        .sr_value(sr_value), .sr_enable(sr_enable), .bit_mask(bit_mask),
        .map_mask(map_mask), .latch(latch), .upd_clr(upd_clr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .plane_updated(plane_updated)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference for the store currently driven
    task automatic model();
        int a, off, pl;
        bit hit;
        a = int'(wr_addr);
        hit = 1'b0;
        off = 0;
        case (map_sel)
            2'd0: begin hit = 1'b1; off = a; end
            2'd1: begin hit = (a < 'h10000); off = (a + int'(bank_off)) % (1 << 19); end
            2'd2: begin hit = (a >= 'h10000 && a < 'h18000); off = a - 'h10000; end
            default: begin hit = (a >= 'h18000); off = a - 'h18000; end
        endcase
        e_we = 1'b0; e_be = '0; e_addr = '0; e_data = '0;
        if (wr_valid && hit) begin
            if (chain4_en || oddeven_en) begin
                if (chain4_en) begin
                    pl = off % 4;
                    e_addr = 19'(off / 4);
                end else begin
                    pl = (int'(plane_sel) & 2) + (off % 2);
                    e_addr = 19'(off / 2);
                end
                e_we = map_mask[pl];
                e_be = e_we ? 4'(1 << pl) : 4'd0;
                for (int p = 0; p < 4; p++) e_data[p*8 +: 8] = wr_data;
            end else begin
                e_addr = 19'(off);
                e_be = map_mask;
                e_we = (map_mask != 0);
                for (int p = 0; p < 4; p++) begin
                    for (int b = 0; b < 8; b++) begin
                        bit lb, rb, v, m, f;
                        lb = latch[p*8 + b];
                        rb = wr_data[(b + int'(rot_cnt)) % 8];
                        v = rb; m = bit_mask[b];
                        case (write_mode)
                            2'd0: v = sr_enable[p] ? sr_value[p] : rb;
                            2'd2: v = wr_data[p];
                            2'd3: begin v = sr_value[p]; m = bit_mask[b] & rb; end
                            default: v = lb;
                        endcase
                        if (write_mode == 2'd1) begin
                            f = lb;
                        end else begin
                            case (logic_fn)
                                2'd1: f = v & lb;
                                2'd2: f = v | lb;
                                2'd3: f = v ^ lb;
                                default: f = v;
                            endcase
                            f = m ? f : lb;
                        end
                        e_data[p*8 + b] = f;
                    end
                end
            end
            if (!e_we) e_be = '0;
        end
        e_upd = (upd_clr ? 4'd0 : e_upd) | e_be;
    endtask

    task automatic step(input string tag);
        model();
        @(negedge clk);
        check(tag, "mem_we", 32'(mem_we), 32'(e_we));
        if (e_we) begin
            check(tag, "mem_addr", 32'(mem_addr), 32'(e_addr));
            check(tag, "mem_be", 32'(mem_be), 32'(e_be));
            check(tag, "mem_wdata", mem_wdata, e_data);
        end
        check(tag, "plane_updated", 32'(plane_updated), 32'(e_upd));
        wr_valid = 1'b0;
        upd_clr = 1'b0;
    endtask

    task automatic store(input logic [16:0] a, input logic [7:0] d, input string tag);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        step(tag);
    endtask

    task automatic planar(input logic [1:0] wm, input logic [1:0] fn,
                          input logic [7:0] d, input string tag);
        write_mode = wm; logic_fn = fn;
        store(17'h00123, d, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "mem_we", 32'(mem_we), 32'd0);
        check("R1", "plane_updated", 32'(plane_updated), 32'd0);
        rst_n = 1'b1;
        step("R13");

        // packed-chain path
        chain4_en = 1'b1;
        store(17'h00000, 8'hA5, "R3");
        store(17'h00007, 8'h3C, "R3");
        map_mask = 4'b1101;
        store(17'h00006, 8'h11, "R3");
        store(17'h00005, 8'h22, "R3");
        upd_clr = 1'b1; step("R12");
        map_mask = 4'hF;
        oddeven_en = 1'b1;
        store(17'h0000E, 8'h44, "R14");

        // windows
        map_sel = 2'd1; bank_off = 19'h20000;
        store(17'h0FFFF, 8'h01, "R2");
        store(17'h10000, 8'h02, "R2");
        map_sel = 2'd2;
        store(17'h10004, 8'h03, "R2");
        store(17'h18000, 8'h04, "R2");
        store(17'h0FFFF, 8'h05, "R2");
        map_sel = 2'd3;
        store(17'h1FFFF, 8'h06, "R2");
        store(17'h17FFF, 8'h07, "R2");
        map_sel = 2'd0;

        // paired-plane path
        chain4_en = 1'b0;
        plane_sel = 2'd0;
        store(17'h00011, 8'h5A, "R4");
        plane_sel = 2'd2;
        store(17'h00010, 8'h6B, "R4");
        store(17'h00013, 8'h7C, "R4");
        map_mask = 4'b0111;
        store(17'h00021, 8'h8D, "R4");
        map_mask = 4'hF;

        // planar raster-op
        oddeven_en = 1'b0;
        latch = 32'hF0C3_5A96;
        bit_mask = 8'hFF; rot_cnt = 3'd3;
        sr_enable = 4'b0101; sr_value = 4'b0001;
        planar(2'd0, 2'd0, 8'hB1, "R5");
        rot_cnt = 3'd0; sr_enable = 4'b0000;
        planar(2'd0, 2'd0, 8'h81, "R5");
        bit_mask = 8'h0F; rot_cnt = 3'd5;
        planar(2'd1, 2'd3, 8'h00, "R6");
        planar(2'd2, 2'd0, 8'h0A, "R7");
        bit_mask = 8'hFF;
        planar(2'd2, 2'd0, 8'h05, "R7");
        bit_mask = 8'h3C; rot_cnt = 3'd1; sr_value = 4'b1010;
        planar(2'd3, 2'd0, 8'hE7, "R8");
        bit_mask = 8'hFF; rot_cnt = 3'd0;
        planar(2'd2, 2'd1, 8'h03, "R9");
        planar(2'd2, 2'd2, 8'h03, "R9");
        planar(2'd2, 2'd3, 8'h03, "R9");
        bit_mask = 8'hA5;
        planar(2'd0, 2'd3, 8'h5F, "R10");
        map_mask = 4'b1001;
        planar(2'd0, 2'd0, 8'h77, "R11");
        map_mask = 4'b0000;
        planar(2'd0, 2'd0, 8'h77, "R11");
        map_mask = 4'b0110; upd_clr = 1'b1;
        planar(2'd2, 2'd0, 8'h0F, "R12");
        step("R13");

        // pseudo-random stores across every configuration
        for (int i = 0; i < 3000; i++) begin
            map_sel    = 2'($urandom);
            bank_off   = 19'($urandom);
            chain4_en  = ($urandom % 4) == 0;
            oddeven_en = ($urandom % 3) == 0;
            plane_sel  = 2'($urandom);
            rot_cnt    = 3'($urandom);
            sr_value   = 4'($urandom);
            sr_enable  = 4'($urandom);
            bit_mask   = 8'($urandom);
            map_mask   = 4'($urandom);
            latch      = $urandom;
            upd_clr    = ($urandom % 10) == 0;
            write_mode = 2'($urandom);
            logic_fn   = 2'($urandom);
            wr_valid   = ($urandom % 5) != 0;
            wr_addr    = 17'($urandom);
            wr_data    = 8'($urandom);
            step("R10");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule